// File: doc/BRIEF.md
# PCI Write Master Issue Controller

This block decides when a buffered write command is launched onto a 32-bit PCI bus and then runs that write transaction. A command buffer presents a target address, a data-phase count, a space selector (memory, I/O or configuration) and a set of byte enables. A write-data buffer reports how many words it currently holds for that command. The controller waits until it is worth starting: either every remaining word is already buffered, or more than a threshold number of phases is buffered (8 by default). Once it holds the bus grant, it drives one address phase carrying the write command code that matches the selected space, then one data phase per buffered word.

A write can end in one of two ways. If the phase count is used up, the command is retired and the buffer head advances. If the latency timer has run out while the grant is withdrawn, the transaction is cut short early. The block then asks the master arbiter to schedule a continuation. The continuation starts at the address that follows the last completed phase and carries only the phases still outstanding. If the buffer runs dry during a burst, the block inserts wait states by holding the initiator-ready signal low.

Frame, initiator-ready and byte enables are active high at this interface, and pad polarity is handled elsewhere. A command length of zero is not allowed. Target-side terminations, parity and read traffic are handled outside this block.

Top module: `wr_master_issue`

## Requirements
- R1: While waiting to start, the address phase (`frame_o` high with `irdy_o` low) begins in the cycle after a cycle in which `gnt_i` was high and either `buf_level_i` >= the outstanding phase count or `buf_level_i` > 8. In no other case does it begin.
- R2: During the address phase, `cbe_o` carries the write command for the space selector. Selector 2'b00 gives 4'b0111 (memory write), 2'b01 gives 4'b0011 (I/O write), 2'b10 gives 4'b1011 (configuration write), and 2'b11 is treated as memory and gives 4'b0111.
- R3: During the first address phase of a command, `ad_o` equals `cmd_addr_i`.
- R4: In a data phase with `irdy_o` high, `ad_o` equals `buf_data_i` and `cbe_o` equals the byte enables latched with the command. `buf_pop_o` is high exactly when `irdy_o` and `trdy_i` are both high.
- R5: `frame_o` is low in the data phase that completes the transaction and in the cycle that follows it. It stays high in every earlier data phase. The completing phase is the one where the outstanding count is 1 or a latency stop is pending, with `irdy_o` high.
- R6: One cycle after the phase that exhausts the count, `cmd_done_o` pulses for one cycle. By then exactly `cmd_len_i` words have been popped.
- R7: The latency timer loads `lat_init_i` on entry to the address phase and decrements once per bus cycle down to 0. When it reads 0 in a data phase while `gnt_i` is low, a stop becomes pending. The stopped transaction ends without `cmd_done_o`, and `cont_req_o` pulses two cycles after its last transfer.
- R8: A continuation's address phase carries `cmd_addr_i` + 4 × (phases already completed). It covers only the phases still outstanding.
- R9: In a data phase, `irdy_o` is high exactly when `buf_level_i` is non-zero. Once asserted without `trdy_i`, it stays high.
- R10: While `rst_n` is low, `frame_o`, `irdy_o`, `buf_pop_o`, `cmd_done_o` and `cont_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | A write command is at the buffer head |
| cmd_addr_i | input | ADDR_W | Byte address of the first phase |
| cmd_len_i | input | CNT_W | Number of data phases (1..MAX_BURST) |
| cmd_space_i | input | 2 | Space selector (00 memory, 01 I/O, 10 configuration) |
| cmd_be_i | input | DATA_W/8 | Byte enables used for every data phase |
| cmd_done_o | output | 1 | Command retired; pops the command buffer |
| buf_level_i | input | CNT_W | Words buffered for the current command |
| buf_data_i | input | DATA_W | Word at the data buffer head |
| buf_pop_o | output | 1 | Head word transferred this cycle |
| gnt_i | input | 1 | Bus grant from the arbiter |
| trdy_i | input | 1 | Target ready |
| lat_init_i | input | LT_W | Latency timer reload value |
| frame_o | output | 1 | Transaction frame, active high |
| irdy_o | output | 1 | Initiator ready, active high |
| ad_o | output | DATA_W | Address / data bus |
| cbe_o | output | DATA_W/8 | Command / byte enables |
| cont_req_o | output | 1 | Continuation request to the master arbiter |

## Verification
The bus outputs `frame_o`, `irdy_o`, `ad_o`, `cbe_o` and `buf_pop_o` are combinational in the current state, buffer level, grant and target ready. They are compared in the same cycle as the inputs that produce them. The address phase is due one cycle after a start condition is seen while waiting. `cmd_done_o` is due one cycle after the completing transfer, and `cont_req_o` two cycles after it. The latency stop is predicted from a bench copy of the timer value that is loaded at the address phase and decremented at each following sample. The bench drives inputs at the falling edge and samples one nanosecond before the rising edge, so every compared value is the one the next rising edge acts on.

// File: rtl/wrmst_pkg.sv
package wrmst_pkg;

   typedef enum logic [1:0] {
      SPC_MEM = 2'd0,
      SPC_IO  = 2'd1,
      SPC_CFG = 2'd2,
      SPC_RSV = 2'd3
   } wr_space_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_ADDR,
      ST_DATA,
      ST_TERM,
      ST_CONT
   } wr_state_e;

   localparam logic [3:0] CMD_MEM_WR = 4'b0111;
   localparam logic [3:0] CMD_IO_WR  = 4'b0011;
   localparam logic [3:0] CMD_CFG_WR = 4'b1011;

   function automatic logic [3:0] space_to_cmd(input wr_space_e s);
      logic [3:0] c;
      case (s)
         SPC_IO:  c = CMD_IO_WR;
         SPC_CFG: c = CMD_CFG_WR;
         default: c = CMD_MEM_WR;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/wrmst_issue_gate.sv
module wrmst_issue_gate #(
   parameter int LVL_W  = 8,
   parameter int THRESH = 8
) (
   input  logic [LVL_W-1:0] level_i,
   input  logic [LVL_W-1:0] remaining_i,
   input  logic             gnt_i,
   output logic             go_o
);

   logic whole_ok;
   logic thr_ok;

   assign whole_ok = (level_i >= remaining_i);

   generate
      if (THRESH == 0) begin : g_whole_only
         assign thr_ok = 1'b0;
      end else begin : g_threshold
         assign thr_ok = (level_i > LVL_W'(THRESH));
      end
   endgenerate

   assign go_o = gnt_i && (whole_ok || thr_ok);

endmodule

// File: rtl/wrmst_lat_timer.sv
module wrmst_lat_timer #(
   parameter int LT_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic            run_i,
   input  logic [LT_W-1:0] init_i,
   output logic            expired_o
);

   logic [LT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= init_i;
      end else if (run_i && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/wrmst_phase_track.sv
module wrmst_phase_track #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 8,
   parameter int STEP   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [CNT_W-1:0]  len_i,
   input  logic              adv_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [CNT_W-1:0]  remaining_o,
   output logic              last_o
);

   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         rem_q  <= '0;
      end else if (load_i) begin
         addr_q <= addr_i;
         rem_q  <= len_i;
      end else if (adv_i) begin
         addr_q <= addr_q + ADDR_W'(STEP);
         rem_q  <= rem_q - 1'b1;
      end
   end

   assign addr_o      = addr_q;
   assign remaining_o = rem_q;
   assign last_o      = (rem_q == CNT_W'(1));

endmodule

// File: rtl/wr_master_issue.sv
module wr_master_issue
   import wrmst_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter int DATA_W        = 32,
   parameter int MAX_BURST     = 128,
   parameter int THRESH_PHASES = 8,
   parameter int LT_W          = 8,
   localparam int BE_W         = DATA_W / 8,
   localparam int CNT_W        = $clog2(MAX_BURST + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid_i,
   input  logic [ADDR_W-1:0] cmd_addr_i,
   input  logic [CNT_W-1:0]  cmd_len_i,
   input  logic [1:0]        cmd_space_i,
   input  logic [BE_W-1:0]   cmd_be_i,
   output logic              cmd_done_o,
   input  logic [CNT_W-1:0]  buf_level_i,
   input  logic [DATA_W-1:0] buf_data_i,
   output logic              buf_pop_o,
   input  logic              gnt_i,
   input  logic              trdy_i,
   input  logic [LT_W-1:0]   lat_init_i,
   output logic              frame_o,
   output logic              irdy_o,
   output logic [DATA_W-1:0] ad_o,
   output logic [BE_W-1:0]   cbe_o,
   output logic              cont_req_o
);

   localparam int STEP = BE_W;

   generate
      if (DATA_W != 32 && DATA_W != 64) begin : g_bad_data_w
         $error("wr_master_issue: DATA_W must be 32 or 64");
      end
      if (ADDR_W > DATA_W) begin : g_bad_addr_w
         $error("wr_master_issue: ADDR_W must not exceed DATA_W");
      end
      if (THRESH_PHASES >= MAX_BURST) begin : g_bad_thresh
         $error("wr_master_issue: THRESH_PHASES must be below MAX_BURST");
      end
      if (LT_W < 1) begin : g_bad_lt_w
         $error("wr_master_issue: LT_W must be at least 1");
      end
   endgenerate

   wr_state_e         st_q, st_d;
   wr_space_e         space_q;
   logic [BE_W-1:0]   be_q;
   logic              stop_q;
   logic              done_q;

   logic              go;
   logic              expired;
   logic              last;
   logic [ADDR_W-1:0] cur_addr;
   logic [CNT_W-1:0]  remaining;
   logic              take_cmd;
   logic              start;
   logic              in_data;
   logic              stop_now;
   logic              final_phase;
   logic              xfer;

   assign take_cmd    = (st_q == ST_IDLE) && cmd_valid_i;
   assign start       = (st_q == ST_WAIT) && go;
   assign in_data     = (st_q == ST_DATA);
   assign stop_now    = stop_q || (expired && !gnt_i);
   assign final_phase = last || stop_now;
   assign irdy_o      = in_data && (buf_level_i != '0);
   assign xfer        = irdy_o && trdy_i;

   wrmst_issue_gate #(
      .LVL_W  (CNT_W),
      .THRESH (THRESH_PHASES)
   ) u_gate (
      .level_i     (buf_level_i),
      .remaining_i (remaining),
      .gnt_i       (gnt_i),
      .go_o        (go)
   );

   wrmst_lat_timer #(
      .LT_W (LT_W)
   ) u_lat (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (start),
      .run_i     ((st_q == ST_ADDR) || in_data),
      .init_i    (lat_init_i),
      .expired_o (expired)
   );

   wrmst_phase_track #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .STEP   (STEP)
   ) u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (take_cmd),
      .addr_i      (cmd_addr_i),
      .len_i       (cmd_len_i),
      .adv_i       (xfer),
      .addr_o      (cur_addr),
      .remaining_o (remaining),
      .last_o      (last)
   );

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE: if (cmd_valid_i) st_d = ST_WAIT;
         ST_WAIT: if (go)          st_d = ST_ADDR;
         ST_ADDR:                  st_d = ST_DATA;
         ST_DATA: if (xfer && final_phase) st_d = ST_TERM;
         ST_TERM: st_d = done_q ? ST_IDLE : ST_CONT;
         ST_CONT:                  st_d = ST_WAIT;
         default:                  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         space_q <= SPC_MEM;
         be_q    <= '0;
         stop_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         st_q <= st_d;
         if (take_cmd) begin
            space_q <= wr_space_e'(cmd_space_i);
            be_q    <= cmd_be_i;
         end
         if (start) begin
            stop_q <= 1'b0;
         end else if (in_data && expired && !gnt_i) begin
            stop_q <= 1'b1;
         end
         if (xfer && final_phase) begin
            done_q <= last;
         end
      end
   end

   assign frame_o    = (st_q == ST_ADDR) || (in_data && !(final_phase && irdy_o));
   assign buf_pop_o  = xfer;
   assign cmd_done_o = (st_q == ST_TERM) && done_q;
   assign cont_req_o = (st_q == ST_CONT);

   always_comb begin
      ad_o  = '0;
      cbe_o = '0;
      if (st_q == ST_ADDR) begin
         ad_o  = DATA_W'(cur_addr);
         cbe_o = BE_W'(space_to_cmd(space_q));
      end else if (in_data) begin
         ad_o  = buf_data_i;
         cbe_o = be_q;
      end
   end

endmodule

// File: rtl/wr_master_issue_chk.sv
module wr_master_issue_chk #(
   parameter int LVL_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             gnt_i,
   input logic             trdy_i,
   input logic [LVL_W-1:0] buf_level_i,
   input logic             frame_o,
   input logic             irdy_o,
   input logic             buf_pop_o,
   input logic             cmd_done_o,
   input logic             cont_req_o
);

   assert_start_needs_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_o) |-> $past(gnt_i));

   assert_pop_on_handshake_R4: assert property (@(posedge clk) disable iff (!rst_n)
      buf_pop_o |-> (irdy_o && trdy_i));

   assert_frame_falls_with_irdy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(frame_o) |-> irdy_o);

   assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done_o |-> ($past(buf_pop_o) && !$past(frame_o)));

   assert_cont_after_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cont_req_o |-> (!frame_o && !irdy_o && $past(!frame_o && !irdy_o)));

   assert_single_outcome_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_done_o && cont_req_o));

   assert_irdy_needs_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irdy_o |-> (buf_level_i != '0));

   assert_irdy_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irdy_o && !trdy_i) |=> irdy_o);

   always_comb begin
      if (!rst_n) begin
         assert_reset_quiet_R10: assert (!frame_o && !irdy_o && !buf_pop_o
                                         && !cmd_done_o && !cont_req_o);
      end
   end

endmodule

bind wr_master_issue wr_master_issue_chk #(
   .LVL_W (CNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .gnt_i       (gnt_i),
   .trdy_i      (trdy_i),
   .buf_level_i (buf_level_i),
   .frame_o     (frame_o),
   .irdy_o      (irdy_o),
   .buf_pop_o   (buf_pop_o),
   .cmd_done_o  (cmd_done_o),
   .cont_req_o  (cont_req_o)
);

// File: tb/wr_master_issue_test.sv
module wr_master_issue_test;

   localparam int CNT_W = 8;

   typedef enum {B_IDLE, B_WAIT, B_DATA, B_TERM, B_CONT} bst_e;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cmd_valid_i = 1'b0;
   logic [31:0]      cmd_addr_i = '0;
   logic [CNT_W-1:0] cmd_len_i = '0;
   logic [1:0]       cmd_space_i = '0;
   logic [3:0]       cmd_be_i = '0;
   logic [CNT_W-1:0] buf_level_i = '0;
   logic [31:0]      buf_data_i = '0;
   logic             gnt_i = 1'b0;
   logic             trdy_i = 1'b0;
   logic [7:0]       lat_init_i = '0;
   logic             cmd_done_o, buf_pop_o, frame_o, irdy_o, cont_req_o;
   logic [31:0]      ad_o;
   logic [3:0]       cbe_o;

   int checks = 0;
   int fails = 0;
   int unsigned seq = 0;
   int cont_seen = 0;

   always #4 clk = ~clk;

   wr_master_issue uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_addr_i(cmd_addr_i),
      .cmd_len_i(cmd_len_i), .cmd_space_i(cmd_space_i), .cmd_be_i(cmd_be_i),
      .cmd_done_o(cmd_done_o), .buf_level_i(buf_level_i), .buf_data_i(buf_data_i),
      .buf_pop_o(buf_pop_o), .gnt_i(gnt_i), .trdy_i(trdy_i), .lat_init_i(lat_init_i),
      .frame_o(frame_o), .irdy_o(irdy_o), .ad_o(ad_o), .cbe_o(cbe_o),
      .cont_req_o(cont_req_o)
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_code(input logic [1:0] s);
      case (s)
         2'b01:   return 4'b0011;
         2'b10:   return 4'b1011;
         default: return 4'b0111;
      endcase
   endfunction

   function automatic logic [31:0] word_of(input int unsigned s, input int unsigned k);
      return (32'(s) << 24) ^ 32'h005A_0000 ^ 32'(k);
   endfunction

   task automatic run_cmd(input logic [31:0] addr, input int len, input logic [1:0] space,
                          input logic [3:0] be, input logic [7:0] lat, input int feed_pct,
                          input int gnt_wait_pct, input int gnt_data_pct, input int trdy_pct,
                          input bit prefill);
      bst_e bs = B_IDLE;
      int   fed = prefill ? len : 0;
      int   consumed = 0;
      int   lt_b = 0;
      int   cyc = 0;
      int   lvl, rem;
      bit   prev_cond = 0, stop_b = 0, term_done = 0, finished = 0, fin, cond;
      seq++;
      @(negedge clk);
      forever begin
         cmd_valid_i = 1'b1;
         cmd_addr_i  = addr;
         cmd_len_i   = CNT_W'(len);
         cmd_space_i = space;
         cmd_be_i    = be;
         lat_init_i  = lat;
         if (fed < len && ($urandom % 100) < feed_pct) fed++;
         buf_level_i = CNT_W'(fed - consumed);
         buf_data_i  = word_of(seq, consumed);
         gnt_i  = (bs == B_DATA) ? (($urandom % 100) < gnt_data_pct)
                                 : (($urandom % 100) < gnt_wait_pct);
         trdy_i = ($urandom % 100) < trdy_pct;
         #3;
         lvl  = fed - consumed;
         rem  = len - consumed;
         cond = gnt_i && (lvl >= rem || lvl > 8);
         chk("R4", "pop vs handshake", buf_pop_o, irdy_o && trdy_i);
         if (bs != B_TERM) chk("R6", "done idle", cmd_done_o, 0);
         if (bs != B_CONT) chk("R7", "cont idle", cont_req_o, 0);
         case (bs)
            B_IDLE: begin
               chk("R1", "frame while idle", frame_o, 0);
               bs = B_WAIT;
               prev_cond = 0;
            end
            B_WAIT: begin
               chk("R1", "start timing", frame_o, prev_cond);
               if (frame_o) begin
                  if (consumed == 0) chk("R3", "address", ad_o, addr);
                  else chk("R8", "resume address", ad_o, 32'(addr + 4 * consumed));
                  chk("R2", "command code", cbe_o, exp_code(space));
                  chk("R1", "irdy in address phase", irdy_o, 0);
                  lt_b = lat;
                  stop_b = 0;
                  bs = B_DATA;
               end else begin
                  prev_cond = cond;
               end
            end
            B_DATA: begin
               lt_b = (lt_b > 0) ? lt_b - 1 : 0;
               if (lt_b == 0 && !gnt_i) stop_b = 1;
               chk("R9", "irdy vs level", irdy_o, lvl > 0);
               fin = (rem == 1) || stop_b;
               chk("R5", "frame in data", frame_o, !(fin && irdy_o));
               if (irdy_o) begin
                  chk("R4", "data word", ad_o, word_of(seq, consumed));
                  chk("R4", "byte enables", cbe_o, be);
               end
               if (irdy_o && trdy_i) begin
                  consumed++;
                  if (fin) begin
                     term_done = (rem == 1);
                     bs = B_TERM;
                  end
               end
            end
            B_TERM: begin
               chk("R5", "frame after end", frame_o, 0);
               chk("R5", "irdy after end", irdy_o, 0);
               chk("R6", "done pulse", cmd_done_o, term_done);
               if (term_done) begin
                  chk("R6", "phase total", consumed, len);
                  finished = 1;
               end else begin
                  bs = B_CONT;
               end
            end
            B_CONT: begin
               chk("R7", "continuation request", cont_req_o, 1);
               chk("R7", "frame in continuation", frame_o, 0);
               cont_seen++;
               bs = B_WAIT;
               prev_cond = 0;
            end
            default: ;
         endcase
         if (finished) break;
         cyc++;
         if (cyc > 4000) begin
            chk("R6", "command finishes", 0, 1);
            break;
         end
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run not finished actual=%0d expected=%0d", 190000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int c0;
      void'($urandom(32'd4711));
      cmd_valid_i = 1'b1;
      gnt_i = 1'b1;
      trdy_i = 1'b1;
      buf_level_i = 8'd5;
      repeat (3) @(negedge clk);
      #3;
      chk("R10", "frame in reset", frame_o, 0);
      chk("R10", "irdy in reset", irdy_o, 0);
      chk("R10", "pop in reset", buf_pop_o, 0);
      chk("R10", "done in reset", cmd_done_o, 0);
      chk("R10", "cont in reset", cont_req_o, 0);
      @(negedge clk);
      cmd_valid_i = 1'b0;
      rst_n = 1'b1;
      // single phase, prefilled, memory space (R2, R3, R6)
      run_cmd(32'h1000_0040, 1, 2'b00, 4'b1111, 8'd40, 100, 100, 100, 100, 1);
      // whole-burst start below the threshold (R1)
      run_cmd(32'h2000_0000, 5, 2'b01, 4'b0011, 8'd40, 100, 100, 100, 100, 0);
      // threshold start: 20 phases fed one per cycle, starts at 9 buffered (R1)
      run_cmd(32'h3000_0100, 20, 2'b10, 4'b1100, 8'd60, 100, 100, 100, 100, 0);
      // reserved selector maps to memory (R2)
      run_cmd(32'h4000_0000, 3, 2'b11, 4'b0101, 8'd40, 100, 100, 100, 100, 1);
      // starved buffer, wait states (R9)
      run_cmd(32'h5000_0000, 24, 2'b00, 4'b1111, 8'd200, 25, 100, 60, 70, 0);
      // latency cut with grant withdrawn, continuations (R7, R8)
      c0 = cont_seen;
      run_cmd(32'h6000_0000, 16, 2'b00, 4'b1001, 8'd3, 100, 100, 0, 100, 1);
      chk("R7", "continuations taken", cont_seen > c0, 1);
      // zero timer reload: one phase per transaction (R7, R8)
      c0 = cont_seen;
      run_cmd(32'h7000_0010, 4, 2'b10, 4'b1111, 8'd0, 100, 100, 0, 100, 1);
      chk("R8", "continuation count", cont_seen - c0, 3);
      // maximum burst
      run_cmd(32'h8000_0000, 128, 2'b00, 4'b1111, 8'd255, 100, 100, 100, 100, 1);
      for (int i = 0; i < 40; i++) begin
         run_cmd($urandom & 32'hFFFF_FFFC, 1 + ($urandom % 48), 2'($urandom),
                 4'($urandom), 8'($urandom % 16), 20 + ($urandom % 80),
                 40 + ($urandom % 60), $urandom % 100, 30 + ($urandom % 70),
                 1'($urandom));
      end
      @(negedge clk);
      cmd_valid_i = 1'b0;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule